// File: doc/BRIEF.md
# Next-Program-Counter and Branch Decision Unit

This unit holds the program counter of a single-cycle processor and works out, in the same cycle, where execution goes next. The decode stage gives it the 4-bit major opcode, the 4-bit function field, the two source operand values and the raw 16-bit immediate. The unit evaluates the branch condition and forms the target. For jump-and-link it also supplies the return address for the register file to write back.

All branches share one major opcode. The function field selects the relation in three parts. One bit chooses whether the second operand is rs2 or the constant zero. One bit inverts the outcome. Two bits pick never, equal, less-than or less-or-equal. A taken branch lands at the sequential address plus four times the sign-extended immediate. Jump-and-link is register-based: the base is rs1, the offset is the scaled immediate, and the two low bits of the result are cleared. The PC register loads the chosen next address on each clock edge while `run` is high. It holds while `run` is low, and a synchronous active-low reset returns it to the start address.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` becomes 0x40 after that edge, whatever `run` is.
- R2: With `rst_n` high, a rising edge with `run` high loads `pc` with the `next_pc` value present before the edge, and a rising edge with `run` low leaves `pc` unchanged.
- R3: For any opcode other than branch (0110) and jump-and-link (1011), `next_pc` is `pc`+4, and `taken` and `link_we` are 0.
- R4: Under opcode 0110, the two-register functions compare rs1 with rs2 as signed 32-bit values. The encodings are: 0000 never, 1000 always, 0001 equal, 1001 not equal, 0010 less, 1010 greater-or-equal, 0011 less-or-equal, 1011 greater.
- R5: Under opcode 0110, the zero-compare functions compare signed rs1 with 0 and ignore rs2. The encodings are: 0101 equal, 1101 not equal, 0110 less, 1110 greater-or-equal, 0111 less-or-equal, 1111 greater.
- R6: For a taken branch, `next_pc` is `pc`+4+4×sext(imm), where bit 15 of imm is the sign. For an untaken branch, `next_pc` is `pc`+4.
- R7: Branch functions 0100 and 1100 are reserved and never taken.
- R8: Under opcode 1011, `link_we` is 1, `link_val` is `pc`+4, and `next_pc` is (rs1+4×sext(imm)) with its two low bits forced to zero.
- R9: `taken` is 1 only for opcode 0110 with a true condition, and `link_we` is 1 only for opcode 1011. The two are never high together.
- R10: Bits 1:0 of `pc` and of `next_pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Allows the PC to load `next_pc` on this edge |
| opcode | input | 4 | Major opcode of the current instruction |
| func | input | 4 | Function field of the current instruction |
| rs1_val | input | 32 | First source operand value |
| rs2_val | input | 32 | Second source operand value |
| imm | input | 16 | Raw immediate field |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address the PC loads on the next enabled edge |
| taken | output | 1 | Branch condition true for a branch opcode |
| link_we | output | 1 | Write-enable for the return address |
| link_val | output | 32 | Return address (`pc`+4) |

## Verification
The bound checker watches, on every cycle, the PC alignment, the hold and load behaviour around `run`, the reset value, and the fall-through address whenever no control transfer occurs. It also checks that `taken` and `link_we` are mutually exclusive and tied to their opcodes. Whether each function code picks the correct relation cannot be checked this way, and neither can signed versus unsigned ordering, the ignored rs2 of zero-compares, or the scaled and masked targets. The bench covers these with its vector table and directed jumps, using negative operands and negative immediates.

// File: rtl/npc_pkg.sv
package npc_pkg;

   // major opcodes the unit reacts to
   localparam logic [3:0] OPC_BRANCH = 4'b0110;
   localparam logic [3:0] OPC_JAL    = 4'b1011;

   // relation selected by the two low function bits
   typedef enum logic [1:0] {
      REL_NEVER = 2'b00,
      REL_EQ    = 2'b01,
      REL_LT    = 2'b10,
      REL_LE    = 2'b11
   } rel_e;

   // decoded branch function field
   typedef struct packed {
      logic invert;    // function bit 3
      logic vs_zero;   // function bit 2
      rel_e rel;       // function bits 1:0
   } brfn_t;

   function automatic brfn_t split_fn(input logic [3:0] fn);
      brfn_t r;
      r.invert  = fn[3];
      r.vs_zero = fn[2];
      r.rel     = rel_e'(fn[1:0]);
      return r;
   endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [XLEN-1:0] a_val,
   input  logic [XLEN-1:0] b_val,
   input  logic [3:0]      fn,
   output logic            cond
);

   brfn_t            dec;
   logic [XLEN-1:0]  rhs;
   logic             is_eq;
   logic             is_lt;
   logic             base;
   logic             reserved;

   assign dec = split_fn(fn);
   assign rhs = dec.vs_zero ? '0 : b_val;
   assign is_eq = (a_val == rhs);

   generate
      if (SIGNED_CMP) begin : g_signed
         assign is_lt = ($signed(a_val) < $signed(rhs));
      end else begin : g_unsigned
         assign is_lt = (a_val < rhs);
      end
   endgenerate

   always_comb begin
      unique case (dec.rel)
         REL_NEVER: base = 1'b0;
         REL_EQ:    base = is_eq;
         REL_LT:    base = is_lt;
         REL_LE:    base = is_lt | is_eq;
         default:   base = 1'b0;
      endcase
   end

   // zero-compare with the "never" relation has no defined meaning
   assign reserved = dec.vs_zero && (dec.rel == REL_NEVER);
   assign cond     = reserved ? 1'b0 : (base ^ dec.invert);

endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16
) (
   input  logic [XLEN-1:0]  pc_val,
   input  logic [XLEN-1:0]  base_val,
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  seq_pc,
   output logic [XLEN-1:0]  br_pc,
   output logic [XLEN-1:0]  jmp_pc
);

   localparam int              EXT_W = XLEN - IMM_W;
   localparam logic [XLEN-1:0] STEP  = XLEN'(4);
   localparam logic [XLEN-1:0] AMASK = XLEN'(3);

   logic [XLEN-1:0] sext;
   logic [XLEN-1:0] word_off;

   assign sext     = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign word_off = sext << 2;
   assign seq_pc   = pc_val + STEP;
   assign br_pc    = seq_pc + word_off;
   assign jmp_pc   = (base_val + word_off) & ~AMASK;

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] RESET_PC = 'h40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [XLEN-1:0] d,
   output logic [XLEN-1:0] q
);

   localparam logic [XLEN-1:0] AMASK = XLEN'(3);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= RESET_PC;
      end else if (run) begin
         q <= d & ~AMASK;
      end
   end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              IMM_W      = 16,
   parameter logic [XLEN-1:0] RESET_PC   = 'h40,
   parameter bit              SIGNED_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [3:0]       opcode,
   input  logic [3:0]       func,
   input  logic [XLEN-1:0]  rs1_val,
   input  logic [XLEN-1:0]  rs2_val,
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  pc,
   output logic [XLEN-1:0]  next_pc,
   output logic             taken,
   output logic             link_we,
   output logic [XLEN-1:0]  link_val
);

   generate
      if (XLEN < IMM_W + 2) begin : g_bad_width
         $error("npc_unit: XLEN must exceed IMM_W by at least 2");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset
         $error("npc_unit: RESET_PC must be word aligned");
      end
   endgenerate

   logic            is_branch;
   logic            is_jal;
   logic            cond;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] br_pc;
   logic [XLEN-1:0] jmp_pc;

   assign is_branch = (opcode == OPC_BRANCH);
   assign is_jal    = (opcode == OPC_JAL);

   npc_cond #(
      .XLEN       (XLEN),
      .SIGNED_CMP (SIGNED_CMP)
   ) u_cond (
      .a_val (rs1_val),
      .b_val (rs2_val),
      .fn    (func),
      .cond  (cond)
   );

   npc_target #(
      .XLEN  (XLEN),
      .IMM_W (IMM_W)
   ) u_target (
      .pc_val   (pc),
      .base_val (rs1_val),
      .imm      (imm),
      .seq_pc   (seq_pc),
      .br_pc    (br_pc),
      .jmp_pc   (jmp_pc)
   );

   assign taken    = is_branch & cond;
   assign link_we  = is_jal;
   assign link_val = seq_pc;

   always_comb begin
      if (is_jal) begin
         next_pc = jmp_pc;
      end else if (taken) begin
         next_pc = br_pc;
      end else begin
         next_pc = seq_pc;
      end
   end

   npc_pc_reg #(
      .XLEN     (XLEN),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .d     (next_pc),
      .q     (pc)
   );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
   import npc_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] RESET_PC = 'h40
) (
   input logic            clk,
   input logic            rst_n,
   input logic            run,
   input logic [3:0]      opcode,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] next_pc,
   input logic            taken,
   input logic            link_we
);

   // R1
   reset_pc_chk: assert property (@(posedge clk)
      !rst_n |=> (pc == RESET_PC));

   // R2
   hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(pc));

   // R2
   load_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (pc == $past(next_pc)));

   // R10
   pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc[1:0] == 2'b00) && (next_pc[1:0] == 2'b00));

   // R3
   fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!taken && !link_we) |-> (next_pc == pc + XLEN'(4)));

   // R9
   taken_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> ((opcode == OPC_BRANCH) && !link_we));

   // R9
   link_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> ((opcode == OPC_JAL) && !taken));

endmodule

bind npc_unit npc_unit_chk #(
   .XLEN     (XLEN),
   .RESET_PC (RESET_PC)
) u_npc_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run),
   .opcode  (opcode),
   .pc      (pc),
   .next_pc (next_pc),
   .taken   (taken),
   .link_we (link_we)
);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;

   localparam real HALF = 2.5;   // 200 MHz

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [3:0]  opcode = 4'h0;
   logic [3:0]  func = 4'h0;
   logic [31:0] rs1_val = '0;
   logic [31:0] rs2_val = '0;
   logic [15:0] imm = '0;
   logic [31:0] pc, next_pc, link_val;
   logic        taken, link_we;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #(HALF) clk = ~clk;

   npc_unit dut (
      .clk(clk), .rst_n(rst_n), .run(run), .opcode(opcode), .func(func),
      .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm), .pc(pc),
      .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_val(link_val)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [3:0]  fn;
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] im;
      logic        tk;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{4'h6, 4'h0, 32'd5,        32'd5,        16'h0003, 1'b0}, // R4 never
      '{4'h6, 4'h8, 32'd5,        32'd6,        16'h0003, 1'b1}, // R4 always
      '{4'h6, 4'h1, 32'd7,        32'd7,        16'hFFFE, 1'b1}, // R4 eq, R6 negative imm
      '{4'h6, 4'h1, 32'd7,        32'd8,        16'hFFFE, 1'b0}, // R4 eq false
      '{4'h6, 4'h9, 32'd7,        32'd8,        16'h0010, 1'b1}, // R4 ne
      '{4'h6, 4'h2, 32'hFFFFFFFF, 32'd1,        16'h0001, 1'b1}, // R4 signed lt
      '{4'h6, 4'h2, 32'd1,        32'hFFFFFFFF, 16'h0001, 1'b0}, // R4 signed lt false
      '{4'h6, 4'h3, 32'd3,        32'd3,        16'h7FFF, 1'b1}, // R4 le, R6 max imm
      '{4'h6, 4'hA, 32'd3,        32'd3,        16'h8000, 1'b1}, // R4 ge, R6 min imm
      '{4'h6, 4'hB, 32'd3,        32'd3,        16'h0002, 1'b0}, // R4 gt equal
      '{4'h6, 4'hB, 32'd1,        32'hFFFFFFFF, 16'h0002, 1'b1}, // R4 gt signed
      '{4'h6, 4'h5, 32'd0,        32'd9,        16'h0004, 1'b1}, // R5 eqz ignores rs2
      '{4'h6, 4'hD, 32'd0,        32'd0,        16'h0004, 1'b0}, // R5 nez false
      '{4'h6, 4'h6, 32'h80000000, 32'd0,        16'h0005, 1'b1}, // R5 ltz
      '{4'h6, 4'h7, 32'd0,        32'd7,        16'h0005, 1'b1}, // R5 lez
      '{4'h6, 4'hE, 32'hFFFFFFFF, 32'd0,        16'h0006, 1'b0}, // R5 gez false
      '{4'h6, 4'hF, 32'd1,        32'hFFFFFFFF, 16'h0006, 1'b1}, // R5 gtz
      '{4'h6, 4'h4, 32'd0,        32'd0,        16'h0007, 1'b0}, // R7 reserved 0100
      '{4'h6, 4'hC, 32'd0,        32'd0,        16'h0007, 1'b0}, // R7 reserved 1100
      '{4'h0, 4'h8, 32'd1,        32'd1,        16'h0008, 1'b0}, // R3 alu-type op
      '{4'hA, 4'h1, 32'd1,        32'd1,        16'h0008, 1'b0}  // R3 compare-type op
   };

   function automatic logic [31:0] sx4(input logic [15:0] v);
      return {{16{v[15]}}, v} << 2;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic drive(input logic r, input logic [3:0] op, input logic [3:0] fn,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im);
      run = r; opcode = op; func = fn; rs1_val = a; rs2_val = b; imm = im;
   endtask

   initial begin
      #(HALF * 2.0 * 200000.0);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(pc == 32'h40, "R1 reset pc", pc, 32'h40);
      check(taken == 1'b0, "R3 idle taken", 32'(taken), 32'd0);
      check(link_we == 1'b0, "R3 idle link_we", 32'(link_we), 32'd0);
      check(next_pc == 32'h44, "R3 idle next_pc", next_pc, 32'h44);

      // table walk with the PC held at 0x40
      for (int i = 0; i < NV; i++) begin
         logic [31:0] exp_np;
         drive(1'b0, VEC[i].op, VEC[i].fn, VEC[i].a, VEC[i].b, VEC[i].im);
         #1;
         exp_np = VEC[i].tk ? (32'h44 + sx4(VEC[i].im)) : 32'h44;
         check(taken == VEC[i].tk, $sformatf("R4 R5 R7 R9 taken vec %0d", i),
               32'(taken), 32'(VEC[i].tk));
         check(next_pc == exp_np, $sformatf("R6 R3 next_pc vec %0d", i), next_pc, exp_np);
         check(link_we == 1'b0, $sformatf("R9 link_we vec %0d", i), 32'(link_we), 32'd0);
         @(negedge clk);
      end
      check(pc == 32'h40, "R2 held through table", pc, 32'h40);

      // jump-and-link, PC held
      drive(1'b0, 4'hB, 4'h0, 32'h1000, 32'h0, 16'h0003);
      #1;
      check(next_pc == 32'h100C, "R8 jal target", next_pc, 32'h100C);
      check(link_val == 32'h44, "R8 link value", link_val, 32'h44);
      check(link_we == 1'b1, "R8 link_we", 32'(link_we), 32'd1);
      check(taken == 1'b0, "R9 jal not taken", 32'(taken), 32'd0);
      drive(1'b0, 4'hB, 4'h0, 32'h1003, 32'h0, 16'hFFFF);
      #1;
      check(next_pc == 32'h0FFC, "R8 R10 jal masked target", next_pc, 32'h0FFC);

      // running sequence
      @(negedge clk);
      drive(1'b1, 4'h0, 4'h0, 32'd0, 32'd0, 16'h0000);
      @(negedge clk);
      check(pc == 32'h44, "R2 sequential advance", pc, 32'h44);
      drive(1'b1, 4'h6, 4'h1, 32'd9, 32'd9, 16'h0004);
      @(negedge clk);
      check(pc == 32'h58, "R2 R6 taken branch loads", pc, 32'h58);
      drive(1'b0, 4'h6, 4'h1, 32'd9, 32'd9, 16'h0004);
      @(negedge clk);
      check(pc == 32'h58, "R2 run low holds", pc, 32'h58);
      drive(1'b1, 4'hB, 4'h0, 32'h200, 32'd0, 16'hFFFF);
      #1;
      check(link_val == 32'h5C, "R8 link value running", link_val, 32'h5C);
      @(negedge clk);
      check(pc == 32'h1FC, "R2 R8 jal loads", pc, 32'h1FC);
      check(pc[1:0] == 2'b00, "R10 pc aligned", {30'd0, pc[1:0]}, 32'd0);
      rst_n = 1'b0;
      @(negedge clk);
      check(pc == 32'h40, "R1 reset while running", pc, 32'h40);
      rst_n = 1'b1;
      drive(1'b0, 4'h0, 4'h0, 32'd0, 32'd0, 16'h0000);
      @(negedge clk);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule